// File: doc/BRIEF.md
# Subroutine and Interrupt Stack Sequencer

This block runs the stack traffic of a small 8-bit processor core in a 16-bit address space. A single command starts one of six sequences: a subroutine call, a subroutine return, a push or pull of one register, interrupt entry, or return from interrupt. The sequencer moves the needed bytes between a working copy of the register file and a byte-wide memory port, one byte per cycle. The stack grows downward, and the stack pointer always names the next free byte.

At the start of a command the block captures the core's register values (program counter, both index registers, both accumulators, condition codes). It then walks the needed bytes. When it finishes, it raises a one-cycle completion strobe. Its register outputs then hold the new state for the core to adopt.

On interrupt entry the sequencer stacks the whole context. It then sets the mask bits and fetches the service address from a two-byte vector. Arbitration is done elsewhere; the vector location arrives already resolved on `target`.

Top module: `stack_seq`

## Requirements
- R1: After reset `sp_out` equals SP_RESET, `ccr_out` equals CCR_RESET, and `busy`, `done`, `mem_we` and `mem_re` are low.
- R2: Every stack write stores at the address in `sp_out` and lowers the stack pointer by one. A 16-bit push (`cmd_op`=2, `cmd_sel`=2 for X index, 3 for Y index) writes the low byte at SP and the high byte at SP-1. A byte push (`cmd_sel`=0 accumulator A, 1 accumulator B) writes one byte at SP.
- R3: Every stack read first raises the stack pointer by one and reads at the new value. A 16-bit pull (`cmd_op`=3) takes the high byte from SP+1 and the low byte from SP+2.
- R4: A call (`cmd_op`=0) stores `pc_in` low byte at SP and high byte at SP-1, leaves SP two lower, and sets `pc_out` to `target`.
- R5: A return (`cmd_op`=1) loads `pc_out` with the high byte from SP+1 and the low byte from SP+2, and leaves SP two higher.
- R6: Interrupt entry (`cmd_op`=4) stores nine bytes at SP down to SP-8 in this order: PC low, PC high, Y low, Y high, X low, X high, A, B, condition codes. The stored condition byte is the value before masking. SP ends nine lower.
- R7: The I mask (bit I_BIT) is set only after the last stack write and before the first vector read. When `cmd_nmi` is high, the X mask (bit X_BIT) is set at the same point. All other condition bits are kept.
- R8: After interrupt entry `pc_out` is the byte at `target` (high) joined with the byte at `target`+1 (low).
- R9: Return from interrupt (`cmd_op`=5) reads nine bytes from SP+1 upward in the exact reverse of the R6 order, restores all registers, and leaves SP nine higher.
- R10: On return from interrupt the restored X mask equals the stacked bit X_BIT ANDed with the X bit of `ccr_in`. Hardware never sets X through this path.
- R11: `done` is a single-cycle pulse. `busy` is high from acceptance until `done`. A command offered while `busy` is high is ignored. Codes 6 and 7 on `cmd_op` start nothing.
- R12: Call, return, push and pull leave `ccr_out` equal to `ccr_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Start a command (taken when idle) |
| cmd_op | input | 3 | 0 call, 1 return, 2 push, 3 pull, 4 interrupt, 5 return from interrupt |
| cmd_sel | input | 2 | Register for push/pull: 0 A, 1 B, 2 X index, 3 Y index |
| cmd_nmi | input | 1 | Interrupt entry also sets the X mask |
| target | input | 16 | Call destination or vector location |
| pc_in | input | 16 | Program counter (return address for calls) |
| iy_in | input | 16 | Y index register |
| ix_in | input | 16 | X index register |
| a_in | input | 8 | Accumulator A |
| b_in | input | 8 | Accumulator B |
| ccr_in | input | 8 | Condition code register |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write byte |
| mem_re | output | 1 | Memory read strobe (data expected in the same cycle) |
| mem_rdata | input | 8 | Memory read byte |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Completion pulse |
| sp_out | output | 16 | Stack pointer |
| pc_out | output | 16 | Resulting program counter |
| iy_out | output | 16 | Resulting Y index |
| ix_out | output | 16 | Resulting X index |
| a_out | output | 8 | Resulting accumulator A |
| b_out | output | 8 | Resulting accumulator B |
| ccr_out | output | 8 | Resulting condition codes |

## Verification
The bench uses ADDR_W 16, the default mask positions (X at bit 6, I at bit 4) and CCR_RESET 8'hD0. It overrides SP_RESET to 16'h0200. With that value, every stack frame and vector location the tests touch falls inside a 4 KB model memory. This allows nested frames: a non-maskable entry stacked directly on top of a maskable one, both unwound in turn. It also allows a hand-built frame above the reset pointer. Together these drive all three X-mask outcomes of R10 through real memory images.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

   typedef enum logic [2:0] {
      OP_CALL = 3'd0,
      OP_RET  = 3'd1,
      OP_PUSH = 3'd2,
      OP_PULL = 3'd3,
      OP_INTR = 3'd4,
      OP_RTI  = 3'd5
   } op_e;

   typedef enum logic [1:0] {
      SEL_A  = 2'd0,
      SEL_B  = 2'd1,
      SEL_IX = 2'd2,
      SEL_IY = 2'd3
   } sel_e;

   // Frame slots in stacking order; pulls walk them downward.
   typedef enum logic [3:0] {
      SL_PCL = 4'd0,
      SL_PCH = 4'd1,
      SL_IYL = 4'd2,
      SL_IYH = 4'd3,
      SL_IXL = 4'd4,
      SL_IXH = 4'd5,
      SL_A   = 4'd6,
      SL_B   = 4'd7,
      SL_CCR = 4'd8
   } slot_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WR,
      ST_RD,
      ST_MASK,
      ST_VHI,
      ST_VLO,
      ST_DONE
   } state_e;

endpackage

// File: rtl/stack_seq_plan.sv
module stack_seq_plan
   import stack_seq_pkg::*;
(
   input  logic [2:0] op,
   input  logic [1:0] sel,
   output logic       known,
   output logic       is_write,
   output logic       needs_vec,
   output slot_e      lo_slot,
   output slot_e      hi_slot
);

   slot_e sel_lo;
   slot_e sel_hi;

   always_comb begin
      unique case (sel_e'(sel))
         SEL_A:   begin sel_lo = SL_A;   sel_hi = SL_A;   end
         SEL_B:   begin sel_lo = SL_B;   sel_hi = SL_B;   end
         SEL_IX:  begin sel_lo = SL_IXL; sel_hi = SL_IXH; end
         default: begin sel_lo = SL_IYL; sel_hi = SL_IYH; end
      endcase
   end

   always_comb begin
      known     = 1'b1;
      is_write  = 1'b0;
      needs_vec = 1'b0;
      lo_slot   = SL_PCL;
      hi_slot   = SL_PCH;
      case (op)
         OP_CALL: is_write = 1'b1;
         OP_RET:  ;
         OP_PUSH: begin is_write = 1'b1; lo_slot = sel_lo; hi_slot = sel_hi; end
         OP_PULL: begin lo_slot = sel_lo; hi_slot = sel_hi; end
         OP_INTR: begin is_write = 1'b1; needs_vec = 1'b1; hi_slot = SL_CCR; end
         OP_RTI:  hi_slot = SL_CCR;
         default: known = 1'b0;
      endcase
   end

endmodule

// File: rtl/stack_seq_regs.sv
module stack_seq_regs
   import stack_seq_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter logic [7:0]  CCR_RESET = 8'hD0,
   parameter int          X_BIT     = 6,
   parameter int          I_BIT     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [15:0]       iy_in,
   input  logic [15:0]       ix_in,
   input  logic [7:0]        a_in,
   input  logic [7:0]        b_in,
   input  logic [7:0]        ccr_in,
   input  slot_e             slot,
   output logic [7:0]        slot_byte,
   input  logic              put_en,
   input  logic [7:0]        put_byte,
   input  logic              jump_en,
   input  logic [ADDR_W-1:0] jump_addr,
   input  logic              mask_en,
   input  logic              mask_nmi,
   input  logic              vhi_en,
   input  logic              vlo_en,
   output logic [ADDR_W-1:0] pc_q,
   output logic [15:0]       iy_q,
   output logic [15:0]       ix_q,
   output logic [7:0]        a_q,
   output logic [7:0]        b_q,
   output logic [7:0]        ccr_q
);

   localparam logic [7:0] X_MASK = 8'(1) << X_BIT;
   localparam logic [7:0] I_MASK = 8'(1) << I_BIT;

   always_comb begin
      unique case (slot)
         SL_PCL:  slot_byte = pc_q[7:0];
         SL_PCH:  slot_byte = pc_q[15:8];
         SL_IYL:  slot_byte = iy_q[7:0];
         SL_IYH:  slot_byte = iy_q[15:8];
         SL_IXL:  slot_byte = ix_q[7:0];
         SL_IXH:  slot_byte = ix_q[15:8];
         SL_A:    slot_byte = a_q;
         SL_B:    slot_byte = b_q;
         default: slot_byte = ccr_q;
      endcase
   end

   // X can only survive a restore if it was already set before it.
   logic [7:0] ccr_restored;
   assign ccr_restored = (put_byte & ~X_MASK) | (put_byte & ccr_q & X_MASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= '0;
         iy_q  <= '0;
         ix_q  <= '0;
         a_q   <= '0;
         b_q   <= '0;
         ccr_q <= CCR_RESET;
      end else if (ld_en) begin
         pc_q  <= pc_in;
         iy_q  <= iy_in;
         ix_q  <= ix_in;
         a_q   <= a_in;
         b_q   <= b_in;
         ccr_q <= ccr_in;
      end else begin
         if (put_en) begin
            case (slot)
               SL_PCL:  pc_q[7:0]  <= put_byte;
               SL_PCH:  pc_q[15:8] <= put_byte;
               SL_IYL:  iy_q[7:0]  <= put_byte;
               SL_IYH:  iy_q[15:8] <= put_byte;
               SL_IXL:  ix_q[7:0]  <= put_byte;
               SL_IXH:  ix_q[15:8] <= put_byte;
               SL_A:    a_q        <= put_byte;
               SL_B:    b_q        <= put_byte;
               default: ccr_q      <= ccr_restored;
            endcase
         end
         if (jump_en) pc_q <= jump_addr;
         if (mask_en) ccr_q <= ccr_q | I_MASK | (mask_nmi ? X_MASK : 8'h00);
         if (vhi_en)  pc_q[15:8] <= put_byte;
         if (vlo_en)  pc_q[7:0]  <= put_byte;
      end
   end

endmodule

// File: rtl/stack_seq_ctrl.sv
module stack_seq_ctrl
   import stack_seq_pkg::*;
#(
   parameter int                ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] SP_RESET = 16'h01FF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [1:0]        cmd_sel,
   input  logic              cmd_nmi,
   input  logic [ADDR_W-1:0] target,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic              mem_re,
   output logic              busy,
   output logic              done,
   output logic              vec_phase,
   output logic [ADDR_W-1:0] sp_q,
   output slot_e             slot_q,
   output logic              ld_en,
   output logic              put_en,
   output logic              jump_en,
   output logic              mask_en,
   output logic              mask_nmi,
   output logic              vhi_en,
   output logic              vlo_en,
   output logic [ADDR_W-1:0] tgt_q
);

   state_e            state_q;
   op_e               op_q;
   slot_e             lo_q;
   slot_e             hi_q;
   logic              nmi_q;

   logic              p_known;
   logic              p_write;
   logic              p_vec;
   slot_e             p_lo;
   slot_e             p_hi;

   stack_seq_plan u_plan (
      .op        (cmd_op),
      .sel       (cmd_sel),
      .known     (p_known),
      .is_write  (p_write),
      .needs_vec (p_vec),
      .lo_slot   (p_lo),
      .hi_slot   (p_hi)
   );

   logic accept;
   assign accept = (state_q == ST_IDLE) && cmd_valid && p_known;

   logic [ADDR_W-1:0] sp_up;
   assign sp_up = sp_q + ADDR_W'(1);

   assign busy      = (state_q != ST_IDLE);
   assign done      = (state_q == ST_DONE);
   assign vec_phase = (state_q == ST_VHI) || (state_q == ST_VLO);
   assign mem_we    = (state_q == ST_WR);
   assign mem_re    = (state_q == ST_RD) || vec_phase;
   assign ld_en     = accept;
   assign put_en    = (state_q == ST_RD);
   assign mask_en   = (state_q == ST_MASK);
   assign mask_nmi  = nmi_q;
   assign vhi_en    = (state_q == ST_VHI);
   assign vlo_en    = (state_q == ST_VLO);
   assign jump_en   = (state_q == ST_WR) && (slot_q == hi_q) && (op_q == OP_CALL);

   always_comb begin
      unique case (state_q)
         ST_WR:   mem_addr = sp_q;
         ST_RD:   mem_addr = sp_up;
         ST_VHI:  mem_addr = tgt_q;
         ST_VLO:  mem_addr = tgt_q + ADDR_W'(1);
         default: mem_addr = sp_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= OP_CALL;
         lo_q    <= SL_PCL;
         hi_q    <= SL_PCL;
         slot_q  <= SL_PCL;
         nmi_q   <= 1'b0;
         tgt_q   <= '0;
         sp_q    <= SP_RESET;
      end else begin
         unique case (state_q)
            ST_IDLE: if (accept) begin
               op_q    <= op_e'(cmd_op);
               lo_q    <= p_lo;
               hi_q    <= p_hi;
               nmi_q   <= cmd_nmi && p_vec;
               tgt_q   <= target;
               slot_q  <= p_write ? p_lo : p_hi;
               state_q <= p_write ? ST_WR : ST_RD;
            end
            ST_WR: begin
               sp_q <= sp_q - ADDR_W'(1);
               if (slot_q == hi_q)
                  state_q <= (op_q == OP_INTR) ? ST_MASK : ST_DONE;
               else
                  slot_q <= slot_e'(slot_q + 4'd1);
            end
            ST_RD: begin
               sp_q <= sp_up;
               if (slot_q == lo_q) state_q <= ST_DONE;
               else                slot_q  <= slot_e'(slot_q - 4'd1);
            end
            ST_MASK: state_q <= ST_VHI;
            ST_VHI:  state_q <= ST_VLO;
            ST_VLO:  state_q <= ST_DONE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/stack_seq.sv
module stack_seq
   import stack_seq_pkg::*;
#(
   parameter int                ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] SP_RESET  = 16'h01FF,
   parameter logic [7:0]        CCR_RESET = 8'hD0,
   parameter int                X_BIT     = 6,
   parameter int                I_BIT     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [1:0]        cmd_sel,
   input  logic              cmd_nmi,
   input  logic [ADDR_W-1:0] target,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [15:0]       iy_in,
   input  logic [15:0]       ix_in,
   input  logic [7:0]        a_in,
   input  logic [7:0]        b_in,
   input  logic [7:0]        ccr_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [7:0]        mem_wdata,
   output logic              mem_re,
   input  logic [7:0]        mem_rdata,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] sp_out,
   output logic [ADDR_W-1:0] pc_out,
   output logic [15:0]       iy_out,
   output logic [15:0]       ix_out,
   output logic [7:0]        a_out,
   output logic [7:0]        b_out,
   output logic [7:0]        ccr_out
);

   generate
      if (ADDR_W != 16) begin : g_bad_width
         $error("stack_seq: program counter bytes need ADDR_W of 16");
      end
      if (X_BIT == I_BIT || X_BIT > 7 || I_BIT > 7 || X_BIT < 0 || I_BIT < 0) begin : g_bad_mask
         $error("stack_seq: mask bit positions must be distinct and within a byte");
      end
   endgenerate

   slot_e             slot;
   logic              ld_en;
   logic              put_en;
   logic              jump_en;
   logic              mask_en;
   logic              mask_nmi;
   logic              vhi_en;
   logic              vlo_en;
   logic              vec_phase;
   logic [ADDR_W-1:0] tgt;

   stack_seq_ctrl #(
      .ADDR_W   (ADDR_W),
      .SP_RESET (SP_RESET)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_sel   (cmd_sel),
      .cmd_nmi   (cmd_nmi),
      .target    (target),
      .mem_addr  (mem_addr),
      .mem_we    (mem_we),
      .mem_re    (mem_re),
      .busy      (busy),
      .done      (done),
      .vec_phase (vec_phase),
      .sp_q      (sp_out),
      .slot_q    (slot),
      .ld_en     (ld_en),
      .put_en    (put_en),
      .jump_en   (jump_en),
      .mask_en   (mask_en),
      .mask_nmi  (mask_nmi),
      .vhi_en    (vhi_en),
      .vlo_en    (vlo_en),
      .tgt_q     (tgt)
   );

   stack_seq_regs #(
      .ADDR_W    (ADDR_W),
      .CCR_RESET (CCR_RESET),
      .X_BIT     (X_BIT),
      .I_BIT     (I_BIT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_en     (ld_en),
      .pc_in     (pc_in),
      .iy_in     (iy_in),
      .ix_in     (ix_in),
      .a_in      (a_in),
      .b_in      (b_in),
      .ccr_in    (ccr_in),
      .slot      (slot),
      .slot_byte (mem_wdata),
      .put_en    (put_en),
      .put_byte  (mem_rdata),
      .jump_en   (jump_en),
      .jump_addr (tgt),
      .mask_en   (mask_en),
      .mask_nmi  (mask_nmi),
      .vhi_en    (vhi_en),
      .vlo_en    (vlo_en),
      .pc_q      (pc_out),
      .iy_q      (iy_out),
      .ix_q      (ix_out),
      .a_q       (a_out),
      .b_q       (b_out),
      .ccr_q     (ccr_out)
   );

endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
   parameter int ADDR_W = 16,
   parameter int I_BIT  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_we,
   input logic              mem_re,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [ADDR_W-1:0] sp_out,
   input logic              busy,
   input logic              done,
   input logic              vec_phase,
   input logic [7:0]        ccr_out
);

   a_r2_write_at_sp: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_addr == sp_out);

   a_r2_write_decrements: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> sp_out == $past(sp_out) - ADDR_W'(1));

   a_r3_read_above_sp: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_re && !vec_phase) |-> mem_addr == sp_out + ADDR_W'(1));

   a_r3_read_increments: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_re && !vec_phase) |=> sp_out == $past(sp_out) + ADDR_W'(1));

   a_r7_mask_before_vector: assert property (@(posedge clk) disable iff (!rst_n)
      vec_phase |-> ccr_out[I_BIT]);

   a_r7_sp_still_in_vector: assert property (@(posedge clk) disable iff (!rst_n)
      vec_phase |=> $stable(sp_out));

   a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r11_one_port_action: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_we && !mem_re && !done));

endmodule

bind stack_seq stack_seq_chk #(
   .ADDR_W (ADDR_W),
   .I_BIT  (I_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_we    (mem_we),
   .mem_re    (mem_re),
   .mem_addr  (mem_addr),
   .sp_out    (sp_out),
   .busy      (busy),
   .done      (done),
   .vec_phase (vec_phase),
   .ccr_out   (ccr_out)
);

// File: tb/stack_seq_tb_top.sv
module stack_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = '0;
   logic [1:0]  cmd_sel = '0;
   logic        cmd_nmi = 1'b0;
   logic [15:0] target = '0;
   logic [15:0] pc_in = '0;
   logic [15:0] iy_in = '0;
   logic [15:0] ix_in = '0;
   logic [7:0]  a_in = '0;
   logic [7:0]  b_in = '0;
   logic [7:0]  ccr_in = '0;
   logic [15:0] mem_addr;
   logic        mem_we;
   logic [7:0]  mem_wdata;
   logic        mem_re;
   logic [7:0]  mem_rdata;
   logic        busy;
   logic        done;
   logic [15:0] sp_out;
   logic [15:0] pc_out;
   logic [15:0] iy_out;
   logic [15:0] ix_out;
   logic [7:0]  a_out;
   logic [7:0]  b_out;
   logic [7:0]  ccr_out;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [7:0] mem [0:4095];

   always #4 clk = ~clk;

   assign mem_rdata = mem[mem_addr[11:0]];
   always @(posedge clk) if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;

   stack_seq #(
      .SP_RESET (16'h0200)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_sel   (cmd_sel),
      .cmd_nmi   (cmd_nmi),
      .target    (target),
      .pc_in     (pc_in),
      .iy_in     (iy_in),
      .ix_in     (ix_in),
      .a_in      (a_in),
      .b_in      (b_in),
      .ccr_in    (ccr_in),
      .mem_addr  (mem_addr),
      .mem_we    (mem_we),
      .mem_wdata (mem_wdata),
      .mem_re    (mem_re),
      .mem_rdata (mem_rdata),
      .busy      (busy),
      .done      (done),
      .sp_out    (sp_out),
      .pc_out    (pc_out),
      .iy_out    (iy_out),
      .ix_out    (ix_out),
      .a_out     (a_out),
      .b_out     (b_out),
      .ccr_out   (ccr_out)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic load_regs(input logic [15:0] pc, input logic [15:0] iy, input logic [15:0] ix,
                            input logic [7:0] a, input logic [7:0] b, input logic [7:0] ccr);
      pc_in = pc; iy_in = iy; ix_in = ix; a_in = a; b_in = b; ccr_in = ccr;
   endtask

   // Offer a command for 'hold' cycles, then wait for the done pulse.
   task automatic run(input logic [2:0] op, input logic [1:0] sel, input logic nmi,
                      input logic [15:0] tgt, input int hold);
      @(negedge clk);
      cmd_op = op; cmd_sel = sel; cmd_nmi = nmi; target = tgt; cmd_valid = 1'b1;
      repeat (hold) @(negedge clk);
      cmd_valid = 1'b0;
      for (int n = 0; n < 40 && !done; n++) @(negedge clk);
      check("R11 done seen", {31'd0, done}, 32'd1);
   endtask

   task automatic t_reset;
      check("R1 sp", {16'd0, sp_out}, 32'h0200);
      check("R1 ccr", {24'd0, ccr_out}, 32'hD0);
      check("R1 busy/done", {30'd0, busy, done}, 32'd0);
   endtask

   task automatic t_push_pull;
      load_regs(16'h0, 16'hFFFF, 16'h1234, 8'h5A, 8'h00, 8'h0F);
      run(3'd2, 2'd0, 1'b0, 16'h0, 1);
      check("R2 push A byte", {24'd0, mem[12'h200]}, 32'h5A);
      check("R2 push A sp", {16'd0, sp_out}, 32'h01FF);
      check("R12 push keeps ccr", {24'd0, ccr_out}, 32'h0F);
      run(3'd2, 2'd2, 1'b0, 16'h0, 1);
      check("R2 push X low at sp", {24'd0, mem[12'h1FF]}, 32'h34);
      check("R2 push X high at sp-1", {24'd0, mem[12'h1FE]}, 32'h12);
      check("R2 push X sp", {16'd0, sp_out}, 32'h01FD);
      ccr_in = 8'h2A;
      run(3'd3, 2'd3, 1'b0, 16'h0, 1);
      check("R3 pull Y value", {16'd0, iy_out}, 32'h1234);
      check("R3 pull Y sp", {16'd0, sp_out}, 32'h01FF);
      check("R12 pull keeps ccr", {24'd0, ccr_out}, 32'h2A);
      run(3'd3, 2'd1, 1'b0, 16'h0, 1);
      check("R3 pull B value", {24'd0, b_out}, 32'h5A);
      check("R3 pull B sp", {16'd0, sp_out}, 32'h0200);
   endtask

   task automatic t_call_ret;
      load_regs(16'hABCD, 16'h0, 16'h0, 8'h0, 8'h0, 8'h81);
      run(3'd0, 2'd0, 1'b0, 16'h0456, 1);
      check("R4 low byte at sp", {24'd0, mem[12'h200]}, 32'hCD);
      check("R4 high byte at sp-1", {24'd0, mem[12'h1FF]}, 32'hAB);
      check("R4 pc to target", {16'd0, pc_out}, 32'h0456);
      check("R4 sp", {16'd0, sp_out}, 32'h01FE);
      check("R12 call keeps ccr", {24'd0, ccr_out}, 32'h81);
      pc_in = 16'h0000;
      run(3'd1, 2'd0, 1'b0, 16'h0, 1);
      check("R5 return pc", {16'd0, pc_out}, 32'hABCD);
      check("R5 sp", {16'd0, sp_out}, 32'h0200);
   endtask

   task automatic t_interrupts;
      logic [7:0] frame [0:8];
      frame = '{8'h57, 8'h13, 8'h68, 8'h24, 8'hBC, 8'h9A, 8'h11, 8'h22, 8'h00};
      mem[12'hFF0] = 8'h8A; mem[12'hFF1] = 8'h55;
      mem[12'hFE0] = 8'h3C; mem[12'hFE1] = 8'hC3;
      load_regs(16'h1357, 16'h2468, 16'h9ABC, 8'h11, 8'h22, 8'h00);
      run(3'd4, 2'd0, 1'b0, 16'h0FF0, 1);
      for (int k = 0; k < 9; k++)
         check("R6 frame byte", {24'd0, mem[12'h200 - 12'(k)]}, {24'd0, frame[k]});
      check("R6 sp", {16'd0, sp_out}, 32'h01F7);
      check("R7 I set, X clear", {24'd0, ccr_out}, 32'h10);
      check("R8 vector pc", {16'd0, pc_out}, 32'h8A55);
      // Non-maskable entry nested on top of the first frame.
      load_regs(16'h2222, 16'h3333, 16'h4444, 8'h55, 8'h66, 8'h05);
      run(3'd4, 2'd0, 1'b1, 16'h0FE0, 1);
      check("R7 nmi sets X and I", {24'd0, ccr_out}, 32'h55);
      check("R6 nmi stacked ccr pre-mask", {24'd0, mem[12'h1EF]}, 32'h05);
      check("R8 nmi vector pc", {16'd0, pc_out}, 32'h3CC3);
      check("R6 nmi sp", {16'd0, sp_out}, 32'h01EE);
      // Unwind nmi frame: X currently set, stacked bit 6 clear.
      load_regs(16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 8'h55);
      run(3'd5, 2'd0, 1'b0, 16'h0, 1);
      check("R9 rti pc", {16'd0, pc_out}, 32'h2222);
      check("R9 rti iy", {16'd0, iy_out}, 32'h3333);
      check("R9 rti ix", {16'd0, ix_out}, 32'h4444);
      check("R9 rti a/b", {16'd0, a_out, b_out}, 32'h5566);
      check("R10 stacked X clear clears X", {24'd0, ccr_out}, 32'h05);
      check("R9 sp", {16'd0, sp_out}, 32'h01F7);
      // Unwind first frame with stacked X forced to 1 while live X is 0.
      mem[12'h1F8] = 8'h4F;
      load_regs(16'hFFFF, 16'hFFFF, 16'hFFFF, 8'hFF, 8'hFF, 8'h00);
      run(3'd5, 2'd0, 1'b0, 16'h0, 1);
      check("R10 X not set by restore", {24'd0, ccr_out}, 32'h0F);
      check("R9 rti pc first frame", {16'd0, pc_out}, 32'h1357);
      check("R9 rti ix/iy", {ix_out, iy_out}, 32'h9ABC2468);
      check("R9 rti a/b first frame", {16'd0, a_out, b_out}, 32'h1122);
      check("R9 sp back to base", {16'd0, sp_out}, 32'h0200);
      // Hand-built frame above SP, live X set and stacked X set.
      mem[12'h201] = 8'hC3; mem[12'h202] = 8'h77; mem[12'h203] = 8'h88;
      mem[12'h204] = 8'hDE; mem[12'h205] = 8'hAD; mem[12'h206] = 8'hBE;
      mem[12'h207] = 8'hEF; mem[12'h208] = 8'h0A; mem[12'h209] = 8'h0B;
      ccr_in = 8'hFF;
      run(3'd5, 2'd0, 1'b0, 16'h0, 1);
      check("R10 X kept when both set", {24'd0, ccr_out}, 32'hC3);
      check("R9 reverse order regs", {ix_out, iy_out}, 32'hDEADBEEF);
      check("R9 reverse order pc/a/b", {pc_out, a_out, b_out}, 32'h0A0B8877);
      check("R9 sp nine higher", {16'd0, sp_out}, 32'h0209);
   endtask

   task automatic t_busy_ignore;
      a_in = 8'hE7;
      run(3'd2, 2'd0, 1'b0, 16'h0, 2);
      @(negedge clk);
      check("R11 done one cycle", {31'd0, done}, 32'd0);
      repeat (4) @(negedge clk);
      check("R11 second offer ignored sp", {16'd0, sp_out}, 32'h0208);
      check("R11 pushed byte", {24'd0, mem[12'h209]}, 32'hE7);
      check("R11 idle after", {31'd0, busy}, 32'd0);
      @(negedge clk);
      cmd_op = 3'd6; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      check("R11 undefined op not busy", {31'd0, busy}, 32'd0);
      repeat (3) @(negedge clk);
      check("R11 undefined op sp", {16'd0, sp_out}, 32'h0208);
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_push_pull();
      t_call_ret();
      t_interrupts();
      t_busy_ignore();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule